// File: doc/BRIEF.md
# Next-Fit Page-Run Allocator with Flush Tracking

This block hands out runs of contiguous pages from a remapping aperture of `N` pages. An internal bitmap marks each page as taken or free. An allocation request carries a run length and an alignment mask. The block scans candidate start pages, one per clock, beginning at a roving next-fit pointer. If that first pass finds nothing, it makes a second pass from page zero. It returns either the start page of the run it claimed or a failure flag. A free request clears a run of pages in one cycle.

Reusing aperture pages can leave stale entries in a downstream translation cache. The block therefore keeps a sticky flag that says a flush is needed. The flag is raised when the search wraps back to page zero, when the pointer runs off the top of the aperture, and on every completed request while full-flush mode is on. A flush request produces a one-cycle flush pulse only if the flag is set, and it clears the flag. The lowest `RESERVED` pages are held as an overflow region from reset and are never handed out.

Requests, frees and flush requests are acted on only in cycles where `busy` is low. If more than one arrives in the same idle cycle, all of them take effect in that cycle: the free and the flush act at once, and the allocation scan starts on the next cycle.

Top module: `page_run_alloc`

## Requirements
- R1: After reset, pages below `RESERVED` are taken and all other pages are free. The next-fit pointer is 0, the flush flag is clear, and `busy` and `done` are low.
- R2: An allocation examines candidate starts in increasing order, beginning at the next-fit pointer. It claims the first candidate where all of the following hold:
  - every page of the run is free;
  - the run ends at or below page `N`;
  - the candidate meets the alignment rule of R6.
- R3: On success the pointer becomes start plus length. If that value is `N` or more, the pointer becomes 0 and the flush flag is set.
- R4: If the pass that starts at the pointer reaches page `N-1` without a fit, the flush flag is set and a second pass runs from page 0.
- R5: If the second pass also reaches page `N-1` without a fit, the request completes with `fail` = 1 and the bitmap is unchanged.
- R6: A returned start `s` satisfies `(s & reqAlign) == 0`.
- R7: A free clears the run's bits. If the freed start is at or above the pointer, the pointer moves to the run's end, or to 0 when that end is `N` or more. The flush flag is not touched.
- R8: Pages below `RESERVED` are never returned, and a free that covers them leaves them taken.
- R9: While `fullFlush` is high, every completed request sets the flush flag, whether it succeeds or fails.
- R10: A flush request gives `flushPulse` = 1 on the next cycle only if the flush flag was set. The flag is cleared at the same edge.
- R11: A request with length 0 or length greater than `N` completes one cycle later with `fail` = 1 and `busy` never raised.
- R12: `busy` is high while a scan runs. One candidate is examined per cycle, so `done` rises after `1 + c` cycles, where `c` is the number of candidates examined. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Allocation request, taken when `busy` is low |
| reqLen | input | $clog2(N+1) | Run length in pages |
| reqAlign | input | $clog2(N) | Alignment mask; start AND mask must be zero |
| fullFlush | input | 1 | Full-flush mode |
| freeValid | input | 1 | Free request, taken when `busy` is low |
| freeStart | input | $clog2(N) | First page of the run to free |
| freeLen | input | $clog2(N+1) | Pages to free |
| flushReq | input | 1 | Flush handshake request, taken when `busy` is low |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Valid with `done`: no run was claimed |
| startIdx | output | $clog2(N) | Valid with `done` and `!fail`: first page of the claimed run |
| flushPulse | output | 1 | One-cycle flush command |
| flushPending | output | 1 | Sticky flush-needed flag |

## Verification
The assertions check on every cycle the rules that hold for any request:
- returned starts are aligned and lie above the reserved region;
- a failed first pass leaves the flush flag set;
- full-flush mode marks every completion;
- bad lengths finish in one cycle without `busy`;
- `done` never coincides with `busy`.

Which start is chosen, how the pointer moves after allocations and frees, the exact scan latency, and when a second pass rescues or fails a request all depend on history. Only the bench's reference model can show those, as it replays sequences of allocations, frees and flushes against the design.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  // strobes from the sequencer to the bitmap datapath
  typedef struct packed {
    logic load;     // latch request, candidate <= next-fit pointer
    logic step;     // candidate <= candidate + 1
    logic restart;  // candidate <= 0, second pass, mark flush needed
    logic commit;   // claim run at candidate
    logic finish;   // complete without claiming
  } allocStrobe_t;
endpackage

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import alloc_pkg::*;
#(
  parameter int N = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [$clog2(N+1)-1:0]    reqLen,
  input  logic                      fits,
  input  logic                      candLast,
  output allocStrobe_t              st,
  output logic                      busy,
  output logic                      done,
  output logic                      fail
);
  localparam int LEN_W = $clog2(N+1);

  typedef enum logic {IDLE, SCAN} state_t;
  state_t state;
  logic   secondPass;
  logic   badLen;

  assign badLen = (reqLen == '0) || (reqLen > LEN_W'(N));
  assign busy   = (state == SCAN);

  always_comb begin
    st = '0;
    if (state == IDLE) begin
      if (reqValid) begin
        if (badLen) st.finish = 1'b1;
        else        st.load   = 1'b1;
      end
    end else begin
      if (fits)             st.commit  = 1'b1;
      else if (!candLast)   st.step    = 1'b1;
      else if (!secondPass) st.restart = 1'b1;
      else                  st.finish  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= IDLE;
      secondPass <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      done <= st.commit || st.finish;
      fail <= st.finish;
      if (st.load)                   state <= SCAN;
      if (st.commit || st.finish)    state <= IDLE;
      if (st.load)                   secondPass <= 1'b0;
      if (st.restart)                secondPass <= 1'b1;
    end
  end

  // R11: bad length completes next cycle as a failure, never busy
  p_bad_len_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && badLen) |=> (done && fail && !busy));
  // R12: a legal request starts a scan
  p_scan_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !badLen) |=> busy);
  // R12: completion pulse only once the scan is over
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/alloc_dp.sv
module alloc_dp
  import alloc_pkg::*;
#(
  parameter int N        = 64,
  parameter int RESERVED = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  allocStrobe_t              st,
  input  logic [$clog2(N+1)-1:0]    reqLen,
  input  logic [$clog2(N)-1:0]      reqAlign,
  input  logic                      fullFlush,
  input  logic                      freeFire,
  input  logic [$clog2(N)-1:0]      freeStart,
  input  logic [$clog2(N+1)-1:0]    freeLen,
  input  logic                      flushFire,
  output logic                      fits,
  output logic                      candLast,
  output logic [$clog2(N)-1:0]      startIdx,
  output logic                      flushPulse,
  output logic                      flushNeeded
);
  localparam int IDX_W = $clog2(N);
  localparam int LEN_W = $clog2(N+1);
  localparam int SUM_W = LEN_W + 1;

  logic [N-1:0]       bitmap, runMask, freeMask;
  logic [IDX_W-1:0]   cand, alignQ, nextIdx;
  logic [LEN_W-1:0]   lenQ;
  logic [SUM_W-1:0]   candEnd, freeEnd;
  logic               setFlag;

  assign candEnd  = SUM_W'(cand) + SUM_W'(lenQ);
  assign freeEnd  = SUM_W'(freeStart) + SUM_W'(freeLen);
  assign candLast = (cand == IDX_W'(N-1));
  assign fits     = ((cand & alignQ) == '0) && (candEnd <= SUM_W'(N)) &&
                    ((bitmap & runMask) == '0);
  assign setFlag  = st.restart ||
                    (st.commit && candEnd >= SUM_W'(N)) ||
                    (fullFlush && (st.commit || st.finish));

  for (genvar i = 0; i < N; i++) begin : g_page
    assign runMask[i]  = (SUM_W'(i) >= SUM_W'(cand)) && (SUM_W'(i) < candEnd);
    assign freeMask[i] = (SUM_W'(i) >= SUM_W'(freeStart)) && (SUM_W'(i) < freeEnd);
    if (i < RESERVED) begin : g_rsv
      assign bitmap[i] = 1'b1;
    end else begin : g_pool
      always_ff @(posedge clk) begin
        if (!rstN)                        bitmap[i] <= 1'b0;
        else if (st.commit && runMask[i]) bitmap[i] <= 1'b1;
        else if (freeFire && freeMask[i]) bitmap[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cand        <= '0;
      alignQ      <= '0;
      lenQ        <= '0;
      nextIdx     <= '0;
      startIdx    <= '0;
      flushPulse  <= 1'b0;
      flushNeeded <= 1'b0;
    end else begin
      flushPulse  <= flushFire && flushNeeded;
      flushNeeded <= (flushNeeded && !flushFire) || setFlag;
      if (st.load) begin
        cand   <= nextIdx;
        lenQ   <= reqLen;
        alignQ <= reqAlign;
      end
      if (st.step)    cand <= cand + 1'b1;
      if (st.restart) cand <= '0;
      if (st.commit) begin
        startIdx <= cand;
        nextIdx  <= (candEnd >= SUM_W'(N)) ? '0 : IDX_W'(candEnd);
      end else if (freeFire && freeStart >= nextIdx) begin
        nextIdx  <= (freeEnd >= SUM_W'(N)) ? '0 : IDX_W'(freeEnd);
      end
    end
  end

  // R6: claimed start respects the latched mask
  p_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> ((startIdx & alignQ) == '0));
  // R4: a failed first pass leaves flush needed
  p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.restart |=> flushNeeded);
  // R10: handshake clears the flag when nothing sets it again
  p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flushFire && !setFlag) |=> !flushNeeded);
  // R10: a pulse only follows a pending flag
  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> $past(flushNeeded));
endmodule

// File: rtl/page_run_alloc.sv
module page_run_alloc
  import alloc_pkg::*;
#(
  parameter int N        = 64,
  parameter int RESERVED = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [$clog2(N+1)-1:0]    reqLen,
  input  logic [$clog2(N)-1:0]      reqAlign,
  input  logic                      fullFlush,
  input  logic                      freeValid,
  input  logic [$clog2(N)-1:0]      freeStart,
  input  logic [$clog2(N+1)-1:0]    freeLen,
  input  logic                      flushReq,
  output logic                      busy,
  output logic                      done,
  output logic                      fail,
  output logic [$clog2(N)-1:0]      startIdx,
  output logic                      flushPulse,
  output logic                      flushPending
);
  allocStrobe_t st;
  logic fits, candLast;

  alloc_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .fits(fits), .candLast(candLast), .st(st),
    .busy(busy), .done(done), .fail(fail)
  );

  alloc_dp #(.N(N), .RESERVED(RESERVED)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqLen(reqLen), .reqAlign(reqAlign),
    .fullFlush(fullFlush), .freeFire(freeValid && !busy),
    .freeStart(freeStart), .freeLen(freeLen),
    .flushFire(flushReq && !busy), .fits(fits), .candLast(candLast),
    .startIdx(startIdx), .flushPulse(flushPulse), .flushNeeded(flushPending)
  );

  // R8: the overflow region is never handed out
  p_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fail) |-> (32'(startIdx) >= RESERVED));
  // R9: full-flush mode marks every completion
  p_fullflush_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(fullFlush)) |-> flushPending);
endmodule

// File: tb/page_run_alloc_test.sv
module page_run_alloc_test;
  localparam int N = 64;
  localparam int RES = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, fullFlush = 1'b0, freeValid = 1'b0, flushReq = 1'b0;
  logic [6:0] reqLen = '0, freeLen = '0;
  logic [5:0] reqAlign = '0, freeStart = '0;
  logic busy, done, fail, flushPulse, flushPending;
  logic [5:0] startIdx;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  bit mbm[N];
  int mnext;
  bit mflag;

  always #2.5 clk = ~clk;

  page_run_alloc #(.N(N), .RESERVED(RES)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .reqAlign(reqAlign), .fullFlush(fullFlush), .freeValid(freeValid),
    .freeStart(freeStart), .freeLen(freeLen), .flushReq(flushReq),
    .busy(busy), .done(done), .fail(fail), .startIdx(startIdx),
    .flushPulse(flushPulse), .flushPending(flushPending)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit fitsAt(int c, int len, int mask);
    if ((c & mask) != 0 || c + len > N) return 0;
    for (int p = c; p < c + len; p++) if (mbm[p]) return 0;
    return 1;
  endfunction

  // R2 R3 R4 R5 R6 R8 R9 R11 R12: one request compared against the model
  task automatic doAlloc(int len, int mask, bit ff);
    int exStart = -1, ncand = 0, cyc = 1;
    bit exFail;
    if (len == 0 || len > N) exFail = 1;
    else begin
      for (int c = mnext; c < N && exStart < 0; c++) begin
        ncand++;
        if (fitsAt(c, len, mask)) exStart = c;
      end
      if (exStart < 0) begin
        mflag = 1;
        for (int c = 0; c < N && exStart < 0; c++) begin
          ncand++;
          if (fitsAt(c, len, mask)) exStart = c;
        end
      end
      exFail = (exStart < 0);
      if (!exFail) begin
        for (int p = exStart; p < exStart + len; p++) mbm[p] = 1;
        mnext = exStart + len;
        if (mnext >= N) begin mnext = 0; mflag = 1; end
      end
    end
    if (ff) mflag = 1;
    @(negedge clk);
    reqValid = 1; reqLen = 7'(len); reqAlign = 6'(mask); fullFlush = ff;
    @(negedge clk);
    reqValid = 0;
    while (!done && cyc < 400) begin
      chk(busy == 1, "R12", "busy during scan", busy, 1);
      @(negedge clk);
      cyc++;
    end
    fullFlush = 0;
    chk(done == 1 && busy == 0, "R12", "done pulse without busy", done, 1);
    chk(cyc == 1 + ncand, "R12", "cycles to done", cyc, 1 + ncand);
    chk(fail == exFail, "R5/R11", "fail flag", fail, exFail);
    if (!exFail) begin
      chk(startIdx == exStart, "R2/R4", "start page", startIdx, exStart);
      chk((startIdx & mask) == 0, "R6", "alignment", startIdx, exStart);
      chk(startIdx >= RES, "R8", "outside reserved", startIdx, RES);
    end
    chk(flushPending == mflag, "R3/R4/R9", "flush flag", flushPending, mflag);
    @(negedge clk);
    chk(done == 0, "R12", "done is one cycle", done, 0);
  endtask

  // R7 R8: free a run
  task automatic doFree(int s, int len);
    for (int p = s; p < s + len && p < N; p++) if (p >= RES) mbm[p] = 0;
    if (s >= mnext) begin
      mnext = s + len;
      if (mnext >= N) mnext = 0;
    end
    @(negedge clk);
    freeValid = 1; freeStart = 6'(s); freeLen = 7'(len);
    @(negedge clk);
    freeValid = 0;
    chk(flushPending == mflag, "R7", "free leaves flush flag", flushPending, mflag);
  endtask

  // R10: flush handshake
  task automatic doFlush();
    bit ex = mflag;
    @(negedge clk);
    flushReq = 1;
    @(negedge clk);
    flushReq = 0;
    chk(flushPulse == ex, "R10", "flush pulse", flushPulse, ex);
    chk(flushPending == 0, "R10", "flag cleared", flushPending, 0);
    mflag = 0;
    @(negedge clk);
    chk(flushPulse == 0, "R10", "pulse one cycle", flushPulse, 0);
  endtask

  initial begin
    for (int p = 0; p < N; p++) mbm[p] = (p < RES);
    mnext = 0; mflag = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(flushPending == 0, "R1", "flag after reset", flushPending, 0);
    doAlloc(1, 0, 0);   // R1 R8: first free page is 32
    doAlloc(4, 3, 0);   // R6: aligned start 36
    doFlush();          // R10: no pulse when flag clear
    doAlloc(0, 0, 0);   // R11
    doAlloc(65, 0, 0);  // R11
    doAlloc(0, 0, 1);   // R9 on failure
    doFlush();
    for (int i = 0; i < 24; i++) begin
      int msk;
      case (i % 4) 0: msk = 0; 1: msk = 1; 2: msk = 3; default: msk = 7; endcase
      doAlloc((i * 7) % 9 + 1, msk, 0);
      if (i % 3 == 2) doFlush();
    end
    doFree(0, 40);      // R8: reserved part stays taken
    doFree(44, 6);
    doFree(56, 8);      // R7: end reaches N, pointer wraps
    for (int i = 0; i < 16; i++) begin
      doAlloc((i * 5) % 7 + 1, (i % 2) ? 1 : 0, i % 5 == 4);
      if (i % 4 == 1) doFree(32 + (i * 9) % 28, (i % 3) + 2);
      if (i % 3 == 0) doFlush();
    end
    doAlloc(32, 0, 0);  // R5: whole pool cannot fit now
    for (int s = RES; s < N; s += 8) doFree(s, 8);
    doAlloc(32, 0, 0);  // full pool after frees
    doFlush();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule